// File: doc/BRIEF.md
# No-turnaround pipelined synchronous SRAM

This block is a synthesizable behavioural model of a small pipelined synchronous static RAM. Reads and writes can follow one another on every clock with no idle cycle when the data bus changes direction. Write data is taken from the bus two clock edges after the write command. Read data leaves an output register in the cycle after the command, so the host can sample it at the second edge. The two latencies line up, so the bus carries the data of one command per cycle whatever mix of reads and writes is issued.

A command is loaded when the advance/load input is low. With that input high, the block repeats the previous operation kind at the next address of a four-beat burst. An internal two-bit counter produces that address in either linear or interleaved order. A clock-hold input makes the block ignore a clock edge entirely. An asynchronous sleep input releases the bus at once and discards the pipeline. An asynchronous output enable gates the data drivers without disturbing the pipeline. A read of a word whose write is still in flight returns that write's bytes merged with the stored bytes.

Top module: `nt_sram`

## Requirements
- R1: After reset the pipeline holds no operation and the block does not drive `dq_io` until a read has been issued.
- R2: A read sampled at clock edge n drives the addressed word on `dq_io` from edge n+1 until edge n+2, provided `oe_n_i` is low and `sleep_i` is low.
- R3: A write sampled at edge n takes its data from `dq_io` at edge n+2. Lane bit i of `lane_wr_n_i` (active low, sampled with the command) enables data bits [8i+7:8i]; disabled lanes keep their old contents.
- R4: Reads and writes may be issued on consecutive edges in any order with no idle cycle. The block never drives `dq_io` during the window in which write data is expected.
- R5: A read issued at the edge right after a write to the same address returns the written lanes merged with the stored lanes.
- R6: With `adv_i` high and `order_i` low, the block repeats the previous operation kind. Address bits [1:0] become the loaded base plus the beat count modulo 4, the upper bits stay at the loaded value, and the sequence wraps after four beats.
- R7: With `adv_i` high and `order_i` high, address bits [1:0] are the loaded base XOR the beat count.
- R8: When `hold_i` is high at a clock edge, no pipeline stage, burst state, memory word or output register changes at that edge.
- R9: While `sleep_i` is high, `dq_io` is released at once. Every edge with `sleep_i` high (and `hold_i` low) empties the pipeline and turns any pending write into a no-op.
- R10: `oe_n_i` high releases `dq_io` at once without affecting the pipeline; a later read returns correct data.
- R11: A command loaded while `sel_i` is low or `sel_n_i` is high is a deselect: nothing is read or written, and bursts that continue it stay deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hold_i | input | 1 | High: ignore this clock edge |
| sleep_i | input | 1 | Asynchronous sleep; bus released, pipeline emptied |
| sel_i | input | 1 | Active-high chip select |
| sel_n_i | input | 1 | Active-low chip select |
| adv_i | input | 1 | Low: load a command; high: next burst beat |
| wr_n_i | input | 1 | Low: write command, high: read command |
| lane_wr_n_i | input | LANES | Active-low byte-lane write enables |
| addr_i | input | ADDR_W | Word address |
| order_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n_i | input | 1 | Asynchronous active-low output enable |
| dq_io | inout | LANES*LANE_W | Bidirectional data bus |

## Verification
The case that stresses the block is a write committing from the bus at the same edge that a read of the same word is captured into the output register. The bench provokes it by issuing a partial-lane write and then a read of the same address on the next edge, and by alternating reads and writes on adjacent addresses. A cycle-by-cycle reference model commits the write before it evaluates the read, and compares the bus value on every cycle. The model also parks a known value on the bus whenever the block should not drive, so a bus fight shows up as a mismatch.

// File: rtl/nt_sram_pkg.sv
package nt_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/nt_sram_rst_sync.sv
module nt_sram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_q = chain_q[STAGES-1];
endmodule

// File: rtl/nt_sram_burst.sv
module nt_sram_burst
  import nt_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              flush,
  input  logic              adv_i,
  input  logic              order_i,
  input  op_e               start_kind,
  input  logic [ADDR_W-1:0] addr_i,
  output op_e               cur_kind,
  output logic [ADDR_W-1:0] cur_addr
);
  localparam int HI_W = ADDR_W - 2;

  op_e             kind_q, kind_n;
  logic [HI_W-1:0] hi_q, hi_n;
  logic [1:0]      base_q, base_n;
  logic [1:0]      cnt_q, cnt_n;
  logic [1:0]      low;

  always_comb begin
    if (!adv_i) begin
      cur_kind = start_kind;
      cur_addr = addr_i;
      hi_n     = addr_i[ADDR_W-1:2];
      base_n   = addr_i[1:0];
      cnt_n    = 2'd0;
      low      = addr_i[1:0];
    end else begin
      cur_kind = kind_q;
      hi_n     = hi_q;
      base_n   = base_q;
      cnt_n    = cnt_q + 2'd1;
      low      = order_i ? (base_q ^ cnt_n) : (base_q + cnt_n);
      cur_addr = {hi_q, low};
    end
    kind_n = flush ? OP_IDLE : cur_kind;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= OP_IDLE;
      hi_q   <= '0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (step_en) begin
      kind_q <= kind_n;
      hi_q   <= hi_n;
      base_q <= base_n;
      cnt_q  <= flush ? 2'd0 : cnt_n;
    end
  end

  // R6 / R7: the fifth beat of a burst lands back on the loaded base
  assert_burst_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !flush && adv_i && kind_q != OP_IDLE && cnt_q == 2'd3)
      |-> cur_addr[1:0] == base_q);
endmodule

// File: rtl/nt_sram_store.sv
module nt_sram_store #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    step_en,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        wr_lanes,
  input  logic [LANES*LANE_W-1:0] bus_in,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              same_word;

  always_ff @(posedge clk) begin
    if (step_en && wr_en) begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_lanes[l]) mem[wr_addr][l*LANE_W +: LANE_W] <= bus_in[l*LANE_W +: LANE_W];
      end
    end
  end

  assign same_word = wr_en && (wr_addr == rd_addr);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_data[g*LANE_W +: LANE_W] = (same_word && wr_lanes[g])
                                         ? bus_in[g*LANE_W +: LANE_W]
                                         : mem[rd_addr][g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/nt_sram.sv
module nt_sram
  import nt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hold_i,
  input  logic                    sleep_i,
  input  logic                    sel_i,
  input  logic                    sel_n_i,
  input  logic                    adv_i,
  input  logic                    wr_n_i,
  input  logic [LANES-1:0]        lane_wr_n_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    order_i,
  input  logic                    oe_n_i,
  inout  wire  [LANES*LANE_W-1:0] dq_io
);
  localparam int DATA_W = LANES * LANE_W;

  logic              rst_q;
  logic              step_en;
  op_e               start_kind, cur_kind;
  logic [ADDR_W-1:0] cur_addr;

  op_e               s1_kind, s1_kind_n, s2_kind, s2_kind_n;
  logic [ADDR_W-1:0] s1_addr, s1_addr_n, s2_addr, s2_addr_n;
  logic [LANES-1:0]  s1_lanes, s1_lanes_n, s2_lanes, s2_lanes_n;
  logic              drive_q, drive_n;
  logic [DATA_W-1:0] out_q, out_n;
  logic [DATA_W-1:0] rd_data;
  logic              commit;

  nt_sram_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_q(rst_q));

  assign step_en    = !hold_i;
  assign start_kind = !(sel_i && !sel_n_i) ? OP_IDLE
                    : (wr_n_i ? OP_READ : OP_WRITE);

  nt_sram_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk(clk), .rst_n(rst_q), .step_en(step_en), .flush(sleep_i),
    .adv_i(adv_i), .order_i(order_i), .start_kind(start_kind),
    .addr_i(addr_i), .cur_kind(cur_kind), .cur_addr(cur_addr));

  assign commit = (s2_kind == OP_WRITE) && !sleep_i;

  nt_sram_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk(clk), .step_en(step_en), .wr_en(commit), .wr_addr(s2_addr),
    .wr_lanes(s2_lanes), .bus_in(dq_io), .rd_addr(s1_addr), .rd_data(rd_data));

  always_comb begin
    s1_kind_n  = cur_kind;
    s1_addr_n  = cur_addr;
    s1_lanes_n = ~lane_wr_n_i;
    s2_kind_n  = s1_kind;
    s2_addr_n  = s1_addr;
    s2_lanes_n = s1_lanes;
    drive_n    = (s1_kind == OP_READ);
    out_n      = (s1_kind == OP_READ) ? rd_data : out_q;
    if (sleep_i) begin
      s1_kind_n = OP_IDLE;
      s2_kind_n = OP_IDLE;
      drive_n   = 1'b0;
      out_n     = out_q;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      s1_kind  <= OP_IDLE;
      s1_addr  <= '0;
      s1_lanes <= '0;
      s2_kind  <= OP_IDLE;
      s2_addr  <= '0;
      s2_lanes <= '0;
      drive_q  <= 1'b0;
      out_q    <= '0;
    end else if (step_en) begin
      s1_kind  <= s1_kind_n;
      s1_addr  <= s1_addr_n;
      s1_lanes <= s1_lanes_n;
      s2_kind  <= s2_kind_n;
      s2_addr  <= s2_addr_n;
      s2_lanes <= s2_lanes_n;
      drive_q  <= drive_n;
      out_q    <= out_n;
    end
  end

  assign dq_io = (drive_q && !oe_n_i && !sleep_i) ? out_q : {DATA_W{1'bz}};

  // R4: never drive while the host owns the bus for write data
  assert_no_bus_fight_R4: assert property (@(posedge clk) disable iff (!rst_q)
    (s2_kind == OP_WRITE) |-> !drive_q);

  // R2: output register only turns on after a read left stage one
  assert_drive_after_read_R2: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(drive_q) |-> $past(s1_kind) == OP_READ);

  // R8: an ignored edge leaves every stage untouched
  assert_hold_freezes_R8: assert property (@(posedge clk) disable iff (!rst_q)
    hold_i |=> ($stable(s1_kind) && $stable(s2_kind) && $stable(drive_q)
                && $stable(out_q) && $stable(s1_addr)));

  // R9: a sleeping edge empties the pipeline
  assert_sleep_flush_R9: assert property (@(posedge clk) disable iff (!rst_q)
    (sleep_i && !hold_i) |=> (!drive_q && s1_kind == OP_IDLE && s2_kind == OP_IDLE));

  // R6: burst beats keep the upper address bits of the loaded command
  assert_burst_upper_R6: assert property (@(posedge clk) disable iff (!rst_q)
    (!hold_i && !sleep_i && adv_i && s1_kind != OP_IDLE)
      |=> s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2]));

  // R11: a deselected load leaves nothing to read or write
  assert_deselect_R11: assert property (@(posedge clk) disable iff (!rst_q)
    (!hold_i && !sleep_i && !adv_i && !(sel_i && !sel_n_i)) |=> s1_kind == OP_IDLE);
endmodule

// File: tb/sim_nt_sram.sv
`timescale 1ns/1ps
module sim_nt_sram;
  localparam int AW = 6;
  localparam int NL = 2;
  localparam int DW = 16;
  localparam logic [DW-1:0] PARK = 16'hA5C3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hold = 1'b0, sleep = 1'b0, sel = 1'b1, sel_n = 1'b0, adv = 1'b0;
  logic wr_n = 1'b1, order = 1'b0, oe_n = 1'b0;
  logic [NL-1:0] lanes_n = '0;
  logic [AW-1:0] addr = '0;
  logic hen = 1'b1;
  logic [DW-1:0] hdat = PARK;
  wire  [DW-1:0] dq;

  assign dq = hen ? hdat : {DW{1'bz}};

  always #10 clk = ~clk;

  nt_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .hold_i(hold), .sleep_i(sleep), .sel_i(sel),
    .sel_n_i(sel_n), .adv_i(adv), .wr_n_i(wr_n), .lane_wr_n_i(lanes_n),
    .addr_i(addr), .order_i(order), .oe_n_i(oe_n), .dq_io(dq));

  // reference model: 0 idle, 1 read, 2 write
  logic [DW-1:0] ref_mem [64];
  int p1k = 0, p2k = 0, bk = 0, bcnt = 0, seq = 0;
  int p1a = 0, p2a = 0, bhi = 0, blo = 0;
  logic [NL-1:0] p1l = '0, p2l = '0;
  logic [DW-1:0] p2d = '0, m_out = '0;
  bit m_drv = 1'b0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic model_edge();
    int k, a;
    if (hold) return;
    if (sleep) begin
      p1k = 0; p2k = 0; m_drv = 0; bk = 0; bcnt = 0;
      return;
    end
    if (p2k == 2) begin
      for (int l = 0; l < NL; l++)
        if (p2l[l]) ref_mem[p2a][l*8 +: 8] = hdat[l*8 +: 8];
    end
    m_drv = (p1k == 1);
    if (p1k == 1) m_out = ref_mem[p1a];
    if (!adv) begin
      k = (sel && !sel_n) ? (wr_n ? 1 : 2) : 0;
      a = int'(addr);
      bhi = a / 4; blo = a % 4; bcnt = 0;
    end else begin
      k = bk;
      bcnt = (bcnt + 1) % 4;
      a = bhi * 4 + (order ? (blo ^ bcnt) : ((blo + bcnt) % 4));
    end
    bk = k;
    p2k = p1k; p2a = p1a; p2l = p1l;
    if (p2k == 2) begin
      seq++;
      p2d = DW'(seq * 16'h1357 + p2a * 16'h0101);
    end
    p1k = k; p1a = a; p1l = ~lanes_n;
  endtask

  task automatic check(input string tag);
    logic [DW-1:0] exp;
    exp = hen ? hdat : m_out;
    checks++;
    if (dq !== exp) begin
      fails++;
      $display("FAIL %s dq=%h expected=%h at %0t", tag, dq, exp, $time);
    end
  endtask

  task automatic host_side();
    bit dev;
    dev = m_drv && !oe_n && !sleep;
    if (p2k == 2 && !sleep) begin hen = 1'b1; hdat = p2d; end
    else if (dev)           begin hen = 1'b0; end
    else                    begin hen = 1'b1; hdat = PARK; end
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    host_side();
    #1;
    check(tag);
  endtask

  task automatic ld(input bit w, input int a, input logic [NL-1:0] ln);
    adv = 1'b0; wr_n = !w; addr = AW'(a); lanes_n = ln; sel = 1'b1; sel_n = 1'b0;
  endtask

  task automatic nop();
    adv = 1'b0; sel = 1'b0; lanes_n = '0;
  endtask

  task automatic beat(input logic [NL-1:0] ln);
    adv = 1'b1; lanes_n = ln;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    nop();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) cyc("R1");

    // fill memory with linear write bursts (R3, R6)
    order = 1'b0;
    for (int b = 0; b < 16; b++) begin
      ld(1, b * 4, 2'b00); cyc("R3");
      for (int i = 0; i < 3; i++) begin beat(2'b00); cyc("R6"); end
    end
    nop(); repeat (2) cyc("R3");

    // linear read burst from a non-zero base, five beats to see the wrap (R6)
    ld(0, 6, 2'b00); cyc("R6");
    for (int i = 0; i < 4; i++) begin beat(2'b00); cyc("R6"); end
    nop(); repeat (2) cyc("R6");

    // interleaved read burst (R7)
    order = 1'b1;
    ld(0, 9, 2'b00); cyc("R7");
    for (int i = 0; i < 4; i++) begin beat(2'b00); cyc("R7"); end
    // interleaved write burst then read back
    ld(1, 15, 2'b00); cyc("R7");
    for (int i = 0; i < 3; i++) begin beat(2'b00); cyc("R7"); end
    ld(0, 15, 2'b00); cyc("R7");
    for (int i = 0; i < 3; i++) begin beat(2'b00); cyc("R7"); end
    order = 1'b0;
    nop(); repeat (2) cyc("R7");

    // read/write interleaving with partial lanes (R4, R3)
    for (int i = 0; i < 12; i++) begin
      ld(i % 2 == 1, 20 + (i % 5), (i % 3 == 0) ? 2'b01 : 2'b00);
      cyc("R4");
    end
    nop(); repeat (2) cyc("R4");

    // write then immediate read of the same word (R5)
    ld(1, 33, 2'b10); cyc("R5");
    ld(0, 33, 2'b00); cyc("R5");
    ld(1, 34, 2'b01); cyc("R5");
    ld(0, 34, 2'b00); cyc("R5");
    ld(0, 33, 2'b00); cyc("R5");
    nop(); repeat (2) cyc("R5");

    // clock hold in the middle of reads and writes (R8)
    ld(0, 40, 2'b00); cyc("R8");
    ld(1, 41, 2'b00); cyc("R8");
    hold = 1'b1; ld(0, 50, 2'b00); repeat (3) cyc("R8");
    hold = 1'b0; ld(0, 41, 2'b00); cyc("R8");
    beat(2'b00); cyc("R8");
    hold = 1'b1; repeat (2) cyc("R8");
    hold = 1'b0; nop(); repeat (3) cyc("R8");

    // output enable release (R10)
    ld(0, 12, 2'b00); cyc("R10");
    oe_n = 1'b1; nop(); cyc("R10");
    cyc("R10");
    oe_n = 1'b0; ld(0, 12, 2'b00); cyc("R10");
    nop(); repeat (2) cyc("R10");

    // sleep: immediate release, ignored commands, discarded write (R9)
    ld(0, 5, 2'b00); cyc("R9");
    nop(); cyc("R9");
    sleep = 1'b1; host_side(); #1; check("R9");
    ld(1, 5, 2'b00); repeat (3) cyc("R9");
    sleep = 1'b0; ld(1, 7, 2'b00); cyc("R9");
    sleep = 1'b1; nop(); cyc("R9");
    cyc("R9");
    sleep = 1'b0; ld(0, 5, 2'b00); cyc("R9");
    ld(0, 7, 2'b00); cyc("R9");
    nop(); repeat (2) cyc("R9");

    // deselect via each select, including a continued burst (R11)
    ld(1, 44, 2'b00); sel_n = 1'b1; cyc("R11");
    beat(2'b00); cyc("R11");
    ld(0, 44, 2'b00); sel = 1'b0; cyc("R11");
    beat(2'b00); cyc("R11");
    ld(0, 44, 2'b00); cyc("R11");
    beat(2'b00); cyc("R11");
    nop(); repeat (3) cyc("R11");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule